// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block is a model of a synchronous single-port SRAM whose inputs and output are all registered. It accepts one command on every enabled clock: a read, a write or a no-op. Any mix of reads and writes follows back to back with no idle cycle between them. The address and control of a write are sampled first, and the write data is sampled two enabled clocks later. Read data appears two enabled clocks after the read address. Writes whose data has not yet reached the array are held in a two-deep write pipeline. A read that hits one of those writes receives the newest bytes, chosen lane by lane.

A command either loads a new address or advances the current burst. An advance steps the two low address bits in linear or interleaved order and keeps the read, write or no-op type of the last load. The chip is selected by three synchronous chip enables. A clock-enable input freezes the whole block. An asynchronous output enable, together with the read pipeline, drives an output-valid flag; that flag stands in for a three-state data bus.

Top module: `zbt_sram`

## Requirements
- R1: A read command accepted at enabled rising edge n puts its word on d_out after enabled edge n+2. In that same cycle q_en is high while oe_n is low. A read command is a selected load with we_n high, or an advance that continues such a load.
- R2: A write command accepted at enabled edge n takes its data from d_in at enabled edge n+2. Later reads of that address return the written bytes.
- R3: Commands may follow one per enabled clock in any order, with no idle cycles. Every read returns the memory state left by all writes issued before it, in command order.
- R4: A read issued one or two commands after writes to the same address returns the newest bytes. The priority is applied per byte lane: the write one command earlier wins, then the write two commands earlier, then the stored word.
- R5: bw_n[i] is active low and controls lane i, which is bits [i*LANE_W +: LANE_W]. A lane whose bw_n bit is high during a write keeps its stored byte.
- R6: A load cycle (adv_ld=0) selects the chip only when ce1_n=0, ce2=1 and ce3_n=0. Any other combination issues a no-op: nothing is written, and q_en stays low in that command's output slot.
- R7: q_en is low in the output slot of a write or a no-op. It is also low, asynchronously, whenever oe_n is high.
- R8: While cen_n is high, a rising edge has no effect. All inputs are ignored, d_out and q_en hold, nothing is written, and the burst state does not move.
- R9: A load (adv_ld=0) takes addr as the burst start, clears the burst count and latches the order from burst_xor (0 selects linear). An advance (adv_ld=1) adds 1 to the count, modulo 4. In linear order the low two address bits are (start+count) mod 4, and the upper bits always stay at the start value.
- R10: In interleaved order (burst_xor=1 at the load), the low two address bits are start XOR count.
- R11: An advance repeats the command type of the last load. The chip enables and we_n are ignored during an advance, while bw_n is sampled on every write cycle.
- R12: After reset, q_en is low, the pipeline holds no command, and the burst state is a no-op, so an advance before the first load does nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cen_n | input | 1 | Clock enable, active low; high freezes the block |
| ce1_n | input | 1 | Chip enable, active low, sampled on load cycles |
| ce2 | input | 1 | Chip enable, active high, sampled on load cycles |
| ce3_n | input | 1 | Chip enable, active low, sampled on load cycles |
| we_n | input | 1 | Low for write, high for read, sampled on load cycles |
| adv_ld | input | 1 | 0 loads a new address, 1 advances the burst |
| burst_xor | input | 1 | Burst order at load: 0 linear, 1 interleaved |
| addr | input | ADDR_W | Word address |
| bw_n | input | LANES | Byte-lane write enables, active low |
| d_in | input | LANES*LANE_W | Write data, sampled two commands after its address |
| oe_n | input | 1 | Asynchronous output enable, active low |
| d_out | output | LANES*LANE_W | Registered read data |
| q_en | output | 1 | High when d_out would drive the bus |

## Verification
The assertions assume that every control pin carries a known level at each rising edge. They also assume that ADDR_W is at least 3, so that the burst bits and the upper address bits are separate fields. Their burst-step checks rely on the order being fixed between loads. The bench satisfies this by driving every input at the falling edge with defined values only, including junk but defined data on d_in when no write data is due. It also fills the whole array before the first read, so no read returns an undefined word.

// File: rtl/zbt_pkg.sv
package zbt_pkg;

  typedef enum logic {
    ORDER_LINEAR = 1'b0,
    ORDER_XOR    = 1'b1
  } burst_order_e;

  // Two-bit burst offset for a given start and step count.
  function automatic logic [1:0] burst_offset(input logic [1:0] start,
                                              input logic [1:0] step,
                                              input burst_order_e ord);
    if (ord == ORDER_XOR) return start ^ step;
    return start + step;
  endfunction

endpackage

// File: rtl/zbt_issue.sv
module zbt_issue
  import zbt_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int LANES  = 2
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              adv_ld,
  input  logic              ce1_n,
  input  logic              ce2,
  input  logic              ce3_n,
  input  logic              we_n,
  input  logic              burst_xor,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANES-1:0]  bw_n,
  output logic              iss_valid,
  output logic              iss_write,
  output logic [ADDR_W-1:0] iss_addr,
  output logic [LANES-1:0]  iss_bw,
  output logic              iss_xor
);

  logic              op_valid, op_write;
  logic [ADDR_W-1:0] base_q;
  logic [1:0]        cnt_q;
  burst_order_e      ord_q;

  logic              n_valid, n_write, selected;
  logic [ADDR_W-1:0] n_base, n_addr;
  logic [1:0]        n_cnt;
  burst_order_e      n_ord;

  always_comb begin
    selected = !ce1_n && ce2 && !ce3_n;
    if (!adv_ld) begin
      n_valid = selected;
      n_write = !we_n;
      n_base  = addr;
      n_cnt   = 2'd0;
      n_ord   = burst_xor ? ORDER_XOR : ORDER_LINEAR;
    end else begin
      n_valid = op_valid;
      n_write = op_write;
      n_base  = base_q;
      n_cnt   = cnt_q + 2'd1;
      n_ord   = ord_q;
    end
    n_addr = {n_base[ADDR_W-1:2], burst_offset(n_base[1:0], n_cnt, n_ord)};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_valid <= 1'b0;
      op_write <= 1'b0;
      base_q   <= '0;
      cnt_q    <= 2'd0;
      ord_q    <= ORDER_LINEAR;
      iss_addr <= '0;
      iss_bw   <= '0;
    end else if (en) begin
      op_valid <= n_valid;
      op_write <= n_write;
      base_q   <= n_base;
      cnt_q    <= n_cnt;
      ord_q    <= n_ord;
      iss_addr <= n_addr;
      iss_bw   <= ~bw_n;
    end
  end

  assign iss_valid = op_valid;
  assign iss_write = op_write;
  assign iss_xor   = (ord_q == ORDER_XOR);

endmodule

// File: rtl/zbt_lane_merge.sv
module zbt_lane_merge #(
  parameter int LANES  = 2,
  parameter int LANE_W = 8,
  localparam int DW    = LANES * LANE_W
)(
  input  logic [DW-1:0]    base_data,
  input  logic             newer_hit,
  input  logic [LANES-1:0] newer_bw,
  input  logic [DW-1:0]    newer_data,
  input  logic             older_hit,
  input  logic [LANES-1:0] older_bw,
  input  logic [DW-1:0]    older_data,
  output logic [DW-1:0]    merged
);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign merged[l*LANE_W +: LANE_W] =
      (newer_hit && newer_bw[l]) ? newer_data[l*LANE_W +: LANE_W] :
      (older_hit && older_bw[l]) ? older_data[l*LANE_W +: LANE_W] :
                                   base_data[l*LANE_W +: LANE_W];
  end

endmodule

// File: rtl/zbt_array.sv
module zbt_array #(
  parameter int ADDR_W = 5,
  parameter int LANES  = 2,
  parameter int LANE_W = 8,
  localparam int DW    = LANES * LANE_W,
  localparam int DEPTH = 1 << ADDR_W
)(
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [LANES-1:0]  wr_bw,
  input  logic [DW-1:0]     wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DW-1:0]     rd_data
);

  for (genvar l = 0; l < LANES; l++) begin : g_bank
    logic [LANE_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_en && wr_bw[l]) cells[wr_addr] <= wr_data[l*LANE_W +: LANE_W];
    end

    assign rd_data[l*LANE_W +: LANE_W] = cells[rd_addr];
  end

endmodule

// File: rtl/zbt_sram.sv
module zbt_sram
  import zbt_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int LANES  = 2,
  parameter int LANE_W = 8,
  localparam int DW    = LANES * LANE_W
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cen_n,
  input  logic              ce1_n,
  input  logic              ce2,
  input  logic              ce3_n,
  input  logic              we_n,
  input  logic              adv_ld,
  input  logic              burst_xor,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANES-1:0]  bw_n,
  input  logic [DW-1:0]     d_in,
  input  logic              oe_n,
  output logic [DW-1:0]     d_out,
  output logic              q_en
);

  logic en;
  assign en = !cen_n;

  // Stage A: issued command
  logic              a_valid, a_write, a_xor;
  logic [ADDR_W-1:0] a_addr;
  logic [LANES-1:0]  a_bw;

  zbt_issue #(.ADDR_W(ADDR_W), .LANES(LANES)) u_issue (
    .clk(clk), .rst_n(rst_n), .en(en), .adv_ld(adv_ld),
    .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .we_n(we_n),
    .burst_xor(burst_xor), .addr(addr), .bw_n(bw_n),
    .iss_valid(a_valid), .iss_write(a_write), .iss_addr(a_addr),
    .iss_bw(a_bw), .iss_xor(a_xor)
  );

  // Stage B: first write-address register / read data register
  logic              b_valid, b_write;
  logic [ADDR_W-1:0] b_addr;
  logic [LANES-1:0]  b_bw;
  logic [DW-1:0]     rd_b;

  // Stage C: second write-address register with captured data
  logic              c_valid;
  logic [ADDR_W-1:0] c_addr;
  logic [LANES-1:0]  c_bw;
  logic [DW-1:0]     c_data;

  // Output register
  logic [DW-1:0] q_reg;
  logic          out_valid;

  logic [DW-1:0] mem_rd, merged;
  logic          newer_hit, older_hit;

  zbt_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk(clk), .wr_en(en && c_valid), .wr_addr(c_addr), .wr_bw(c_bw),
    .wr_data(c_data), .rd_addr(a_addr), .rd_data(mem_rd)
  );

  assign newer_hit = b_valid && b_write && (b_addr == a_addr);
  assign older_hit = c_valid && (c_addr == a_addr);

  zbt_lane_merge #(.LANES(LANES), .LANE_W(LANE_W)) u_merge (
    .base_data(mem_rd),
    .newer_hit(newer_hit), .newer_bw(b_bw), .newer_data(d_in),
    .older_hit(older_hit), .older_bw(c_bw), .older_data(c_data),
    .merged(merged)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b_valid   <= 1'b0;
      b_write   <= 1'b0;
      b_addr    <= '0;
      b_bw      <= '0;
      rd_b      <= '0;
      c_valid   <= 1'b0;
      c_addr    <= '0;
      c_bw      <= '0;
      c_data    <= '0;
      q_reg     <= '0;
      out_valid <= 1'b0;
    end else if (en) begin
      b_valid   <= a_valid;
      b_write   <= a_write;
      b_addr    <= a_addr;
      b_bw      <= a_bw;
      rd_b      <= merged;
      c_valid   <= b_valid && b_write;
      c_addr    <= b_addr;
      c_bw      <= b_bw;
      c_data    <= d_in;
      out_valid <= b_valid && !b_write;
      if (b_valid && !b_write) q_reg <= rd_b;
    end
  end

  assign d_out = q_reg;
  assign q_en  = out_valid && !oe_n;

endmodule

// File: rtl/zbt_sram_chk.sv
module zbt_sram_chk #(
  parameter int ADDR_W = 5,
  parameter int DW     = 16
)(
  input logic              clk,
  input logic              rst_n,
  input logic              cen_n,
  input logic              adv_ld,
  input logic              ce1_n,
  input logic              ce2,
  input logic              ce3_n,
  input logic              q_en,
  input logic [DW-1:0]     d_out,
  input logic              a_valid,
  input logic              a_xor,
  input logic [ADDR_W-1:0] a_addr,
  input logic              b_valid,
  input logic              b_write
);

  AST_DESELECT_NOOP: assert property (@(posedge clk) disable iff (!rst_n)
    (!cen_n && !adv_ld && !(!ce1_n && ce2 && !ce3_n)) |=> !a_valid); // R6

  AST_WRITE_SLOT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!cen_n && b_valid && b_write) |=> !q_en); // R7

  AST_FREEZE_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
    cen_n |=> $stable(d_out)); // R8

  AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!cen_n && adv_ld && a_valid && !a_xor) |=>
      (a_valid && (a_addr[1:0] == $past(a_addr[1:0]) + 2'd1))); // R9

  AST_UPPER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cen_n && adv_ld) |=> (a_addr[ADDR_W-1:2] == $past(a_addr[ADDR_W-1:2]))); // R9

  AST_XOR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!cen_n && adv_ld && a_valid && a_xor) |=> (a_addr[0] != $past(a_addr[0]))); // R10

endmodule

bind zbt_sram zbt_sram_chk #(.ADDR_W(ADDR_W), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cen_n(cen_n), .adv_ld(adv_ld),
  .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .q_en(q_en), .d_out(d_out),
  .a_valid(a_valid), .a_xor(a_xor), .a_addr(a_addr),
  .b_valid(b_valid), .b_write(b_write)
);

// File: tb/zbt_sram_test.sv
module zbt_sram_test;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int AW    = 5;
  localparam int LN    = 2;
  localparam int LW    = 8;
  localparam int DW    = LN * LW;
  localparam int DEPTH = 1 << AW;
  localparam logic [2:0] SEL = 3'b010; // {ce1_n, ce2, ce3_n}

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cen_n = 1'b0, ce1_n = 1'b1, ce2 = 1'b0, ce3_n = 1'b1;
  logic we_n = 1'b1, adv_ld = 1'b0, burst_xor = 1'b0, oe_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [LN-1:0] bw_n = '1;
  logic [DW-1:0] d_in = '0;
  logic [DW-1:0] d_out;
  logic          q_en;

  always #2.5 clk = ~clk;

  zbt_sram #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW)) uut (
    .clk(clk), .rst_n(rst_n), .cen_n(cen_n), .ce1_n(ce1_n), .ce2(ce2),
    .ce3_n(ce3_n), .we_n(we_n), .adv_ld(adv_ld), .burst_xor(burst_xor),
    .addr(addr), .bw_n(bw_n), .d_in(d_in), .oe_n(oe_n),
    .d_out(d_out), .q_en(q_en)
  );

  int n_checks = 0;
  int n_err = 0;
  bit done = 1'b0;

  // Reference model state
  logic [DW-1:0] ref_mem [DEPTH];
  bit            m_valid, m_write, m_xor;
  logic [AW-1:0] m_base;
  logic [1:0]    m_cnt;
  bit            s1_v, s1_w, s2_v, s2_w, o_v;
  logic [DW-1:0] s1_d, s2_d, o_d;
  logic [DW-1:0] dseq = 16'hACE1;

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [DW-1:0] lfsr(input logic [DW-1:0] v);
    return {v[DW-2:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  task automatic model_reset();
    m_valid = 0; m_write = 0; m_xor = 0; m_base = '0; m_cnt = 0;
    s1_v = 0; s1_w = 0; s2_v = 0; s2_w = 0; o_v = 0;
    s1_d = '0; s2_d = '0; o_d = '0;
  endtask

  // One clock: drive after a falling edge, sample at the next falling edge.
  task automatic step(input bit cen, input logic [2:0] ce, input bit we, input bit adv,
                      input bit xr, input logic [AW-1:0] a, input logic [LN-1:0] bwn,
                      input bit oe, input string tag);
    logic [1:0]    lo;
    logic [AW-1:0] ea;
    logic [DW-1:0] nd;
    bit            nv, nw;
    cen_n = cen; {ce1_n, ce2, ce3_n} = ce; we_n = we; adv_ld = adv;
    burst_xor = xr; addr = a; bw_n = bwn; oe_n = oe;
    d_in = (!cen && s2_v && s2_w) ? s2_d : (dseq ^ 16'h5A5A);
    nv = 0; nw = 0; nd = '0;
    if (!cen) begin
      if (!adv) begin
        m_valid = (ce == SEL); m_write = !we; m_base = a; m_cnt = 0; m_xor = xr;
      end else begin
        m_cnt = m_cnt + 2'd1;
      end
      lo = m_xor ? (m_base[1:0] ^ m_cnt) : 2'((int'(m_base[1:0]) + int'(m_cnt)) % 4);
      ea = {m_base[AW-1:2], lo};
      nv = m_valid; nw = m_write;
      if (nv && nw) begin
        dseq = lfsr(dseq);
        nd = dseq;
        for (int l = 0; l < LN; l++)
          if (!bwn[l]) ref_mem[ea][l*LW +: LW] = nd[l*LW +: LW];
      end else if (nv) begin
        nd = ref_mem[ea];
      end
    end
    @(posedge clk);
    @(negedge clk);
    if (!cen) begin
      o_v = s2_v && !s2_w;
      if (o_v) o_d = s2_d;
      s2_v = s1_v; s2_w = s1_w; s2_d = s1_d;
      s1_v = nv;   s1_w = nw;   s1_d = nd;
    end
    check(tag, DW'(q_en), DW'(o_v && !oe));
    if (o_v) check(tag, d_out, o_d);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [LN-1:0] mask, input string tag);
    step(0, SEL, 0, 0, 0, a, ~mask, 0, tag);
  endtask

  task automatic rd(input logic [AW-1:0] a, input string tag);
    step(0, SEL, 1, 0, 0, a, '1, 0, tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(0, 3'b111, 1, 0, 0, '0, '1, 0, tag);
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    check("R12", DW'(q_en), '0);
    rst_n = 1'b1;
    // advance before any load is a no-op (R12)
    step(0, SEL, 0, 1, 0, 5'd3, '0, 0, "R12");
    step(0, SEL, 1, 1, 0, 5'd3, '0, 0, "R12");
    idle(3, "R12");

    // fill every word, then read every word back-to-back (R2, R1)
    for (int a = 0; a < DEPTH; a++) wr(AW'(a), 2'b11, "R2");
    for (int a = 0; a < DEPTH; a++) rd(AW'(a), "R1");
    idle(2, "R1");

    // alternating reads and writes with no gaps (R3)
    for (int i = 0; i < 64; i++) begin
      if (i % 2 == 0) wr(AW'((i * 7) % DEPTH), 2'b11, "R3");
      else            rd(AW'((i * 7 - 7) % DEPTH), "R3");
    end

    // forwarding distance sweep with every lane mask (R4, R5)
    for (int gap = 1; gap <= 4; gap++)
      for (int m = 0; m < 4; m++) begin
        wr(5'd9, LN'(m), "R5");
        for (int f = 1; f < gap; f++) rd(5'd20, "R4");
        rd(5'd9, "R4");
      end
    // two pending writes to one address, every mask pair (R4)
    for (int m1 = 0; m1 < 4; m1++)
      for (int m2 = 0; m2 < 4; m2++) begin
        wr(5'd14, LN'(m1), "R4");
        wr(5'd14, LN'(m2), "R4");
        rd(5'd14, "R4");
      end
    idle(2, "R4");

    // every non-selecting chip-enable pattern issues nothing (R6)
    for (int c = 0; c < 8; c++) begin
      if (3'(c) != SEL) begin
        step(0, 3'(c), 0, 0, 0, 5'd17, 2'b00, 0, "R6");
        step(0, 3'(c), 1, 0, 0, 5'd17, 2'b00, 0, "R6");
        rd(5'd17, "R6");
      end
    end
    idle(2, "R6");

    // bursts in both orders from each start offset, wrapping (R9, R10, R11)
    for (int xr = 0; xr < 2; xr++)
      for (int b = 0; b < 4; b++) begin
        logic [AW-1:0] st;
        st = AW'((b + 4 * (xr * 3 + b)) % DEPTH);
        step(0, SEL, 0, 0, 1'(xr), st, 2'b00, 0, xr ? "R10" : "R9");
        for (int k = 0; k < 5; k++)
          step(0, 3'b111, 1, 1, 1'(~xr), 5'd0, LN'(k % 3), 0, "R11");
        step(0, SEL, 1, 0, 1'(xr), st, 2'b00, 0, xr ? "R10" : "R9");
        for (int k = 0; k < 5; k++)
          step(0, 3'b101, 0, 1, 1'(~xr), 5'd31, 2'b00, 0, xr ? "R10" : "R9");
      end
    // deselect load, then advances with selecting pins stay no-ops (R11)
    step(0, 3'b000, 0, 0, 0, 5'd4, 2'b00, 0, "R11");
    for (int k = 0; k < 3; k++) step(0, SEL, 0, 1, 0, 5'd4, 2'b00, 0, "R11");
    for (int a = 4; a < 8; a++) rd(AW'(a), "R11");
    idle(2, "R11");

    // output enable gating on read slots (R7)
    for (int i = 0; i < 16; i++) step(0, SEL, i % 3 == 0, 0, 0, AW'(i), 2'b01, i % 2 == 1, "R7");
    idle(2, "R7");

    // clock-enable freeze with junk on every pin (R8)
    for (int i = 0; i < 400; i++) begin
      bit frz;
      frz = ($urandom % 3) == 0;
      step(frz, frz ? 3'($urandom) : SEL, 1'($urandom), frz ? 1'($urandom) : 1'b0,
           1'($urandom), AW'($urandom), LN'($urandom), 0, "R8");
    end

    // broad random traffic (R3)
    for (int i = 0; i < 3000; i++) begin
      step(($urandom % 5) == 0, (($urandom % 5) == 0) ? 3'($urandom) : SEL,
           1'($urandom), 1'($urandom), 1'($urandom), AW'($urandom), LN'($urandom),
           ($urandom % 7) == 0, "R3");
    end
    idle(4, "R3");
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      n_checks++;
      n_err++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  end

endmodule